// File: doc/BRIEF.md
# Four-Mode Pulse Width Modulator

This block drives one output pin with a pulse train chosen from four modes. The pin can be held low. It can run a fixed 256-tick PWM whose high time is set by an 8-bit duty value. It can run a fast pulse-density waveform that spreads single-tick high pulses as evenly as it can. It can also run a variable-frequency square wave whose high and low times are programmed separately as 13-bit counts. At a 100 MHz clock one tick is 10 ns. The fixed PWM then runs at about 390 kHz. The variable mode spans 50 MHz down to about 6.1 kHz.

Software writes four registers through a plain write strobe with a 2-bit select. Every write lands in a pending copy of the settings. The pending copy moves into the active copy when the running waveform allows it:

- In the fixed and variable modes this happens only at the end of a complete period, so no period is ever cut short.
- In fast and off modes it happens on every clock.

When the active mode changes, the engine for the new mode starts from its reset state.

Top module: `pwm_multimode`

## Requirements
- R1: Writes with `wr_sel` 0 set the mode from `wr_data[1:0]` (0 off, 1 fixed, 2 fast, 3 variable). `wr_sel` 1 sets the duty from `wr_data[7:0]`. `wr_sel` 2 sets the high count and `wr_sel` 3 sets the low count, each from `wr_data[12:0]`.
- R2: After reset, and whenever off mode is active, `pwm_out` stays low and all engine state is held cleared.
- R3: In fixed mode each period is 256 ticks: `duty` ticks high followed by 256-`duty` ticks low. A duty of 0 gives a constant low.
- R4: In fast mode any 255 consecutive ticks contain exactly `duty` high ticks. Duty 0 gives a constant low and duty 255 gives a constant high.
- R5: In fast mode, with a duty of 127 or less, two consecutive high ticks never occur.
- R6: In variable mode the output is high for (high count + 1) ticks and then low for (low count + 1) ticks, for counts from 0 to 8191.
- R7: On entry to variable mode the waveform begins with its high phase. From off mode, the output is high in the second cycle after the cycle in which the mode write is presented.
- R8: The duty value has no effect in variable mode. The high and low counts have no effect in fixed mode.
- R9: In fixed and variable modes a write made during a period leaves that period unchanged; the new setting applies from the next period.
- R10: In fast mode a duty write reaches the output in the third cycle after the cycle in which the write is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mode, 1 duty, 2 high count, 3 low count |
| wr_data | input | 13 | Write data |
| pwm_out | output | 1 | Waveform output |

## Verification
The hardest condition to create from the ports is a write that arrives in the middle of a running period. The check must show that the period completes with the old setting and that the following one uses the new setting.

The bench first waits for a rising edge on the output. It then issues the write a few ticks into the high phase while still counting that phase. Only after that does it measure the next full period. Fast mode is checked by counting high ticks over 255-tick windows for random duties. This count is exact whatever the accumulator's starting state.

// File: rtl/pwm_mm_pkg.sv
package pwm_mm_pkg;

    localparam int DUTY_W = 8;
    localparam int PER_W  = 13;
    localparam int DATA_W = (PER_W > DUTY_W) ? PER_W : DUTY_W;

    // Fast-mode accumulator wraps at 2^DUTY_W - 1 so that full duty means always high.
    localparam logic [DUTY_W:0] FAST_MOD = {1'b0, {DUTY_W{1'b1}}};

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_STD  = 2'd1,
        MODE_FAST = 2'd2,
        MODE_VAR  = 2'd3
    } pwm_mode_e;

    typedef enum logic [1:0] {
        SEL_MODE = 2'd0,
        SEL_DUTY = 2'd1,
        SEL_HIGH = 2'd2,
        SEL_LOW  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        pwm_mode_e           mode;
        logic [DUTY_W-1:0]   duty;
        logic [PER_W-1:0]    hi_cnt;
        logic [PER_W-1:0]    lo_cnt;
    } pwm_cfg_t;

    // One accumulator step: returns {carry, next accumulator}.
    function automatic logic [DUTY_W:0] fast_step(input logic [DUTY_W-1:0] acc,
                                                  input logic [DUTY_W-1:0] duty);
        logic [DUTY_W:0] sum;
        sum = {1'b0, acc} + {1'b0, duty};
        if (sum >= FAST_MOD)
            return {1'b1, DUTY_W'(sum - FAST_MOD)};
        else
            return {1'b0, sum[DUTY_W-1:0]};
    endfunction

endpackage

// File: rtl/pwm_std_engine.sv
module pwm_std_engine
    import pwm_mm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DUTY_W-1:0] duty,
    output logic              out,
    output logic              at_wrap,
    output logic              idle
);
    localparam logic [DUTY_W-1:0] CNT_MAX = {DUTY_W{1'b1}};

    logic [DUTY_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign out     = en && (cnt < duty);
    assign at_wrap = en && (cnt == CNT_MAX);
    assign idle    = (cnt == '0);

    // R3: the period counter wraps to zero after its last tick.
    a_r3_std_wrap: assert property (@(posedge clk) disable iff (rst)
        (en && cnt == CNT_MAX) |=> (cnt == '0));

    // R2: the counter is cleared one cycle after the engine is disabled.
    a_r2_std_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0));

endmodule

// File: rtl/pwm_fast_engine.sv
module pwm_fast_engine
    import pwm_mm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DUTY_W-1:0] duty,
    output logic              out,
    output logic              idle
);
    logic [DUTY_W-1:0] acc;
    logic              out_q;
    logic [DUTY_W:0]   step;

    always_comb step = fast_step(acc, duty);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            acc   <= '0;
            out_q <= 1'b0;
        end else begin
            acc   <= step[DUTY_W-1:0];
            out_q <= step[DUTY_W];
        end
    end

    assign out  = out_q;
    assign idle = (acc == '0) && !out_q;

    // R4: the accumulator never reaches the modulus.
    a_r4_acc_bound: assert property (@(posedge clk) disable iff (rst)
        acc < FAST_MOD[DUTY_W-1:0]);

    // R4: full duty drives the output high on the next tick.
    a_r4_full_high: assert property (@(posedge clk) disable iff (rst)
        (en && duty == {DUTY_W{1'b1}}) |=> out_q);

    // R4: zero duty drives the output low on the next tick.
    a_r4_zero_low: assert property (@(posedge clk) disable iff (rst)
        (en && duty == '0) |=> !out_q);

    // R5: below half duty a high tick is always followed by a low tick.
    a_r5_no_pair: assert property (@(posedge clk) disable iff (rst)
        (en && out_q && !duty[DUTY_W-1] && $stable(duty)) |=> !out_q);

endmodule

// File: rtl/pwm_var_engine.sv
module pwm_var_engine
    import pwm_mm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PER_W-1:0] hi_cnt,
    input  logic [PER_W-1:0] lo_cnt,
    output logic             out,
    output logic             at_wrap,
    output logic             idle
);
    logic [PER_W-1:0] cnt;
    logic             in_high;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt     <= '0;
            in_high <= 1'b1;
        end else if (in_high) begin
            if (cnt == hi_cnt) begin
                cnt     <= '0;
                in_high <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            if (cnt == lo_cnt) begin
                cnt     <= '0;
                in_high <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign out     = en && in_high;
    assign at_wrap = en && !in_high && (cnt == lo_cnt);
    assign idle    = (cnt == '0) && in_high;

    // R6: the phase counter never runs past the programmed count.
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt <= (in_high ? hi_cnt : lo_cnt)));

    // R7: a freshly enabled engine begins in its high phase.
    a_r7_start_high: assert property (@(posedge clk) disable iff (rst)
        !en |=> (in_high && cnt == '0));

endmodule

// File: rtl/pwm_multimode.sv
module pwm_multimode
    import pwm_mm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_out
);
    pwm_cfg_t pend;
    pwm_cfg_t act;

    logic std_out, std_wrap, std_idle;
    logic fast_out, fast_idle;
    logic var_out, var_wrap, var_idle;
    logic load_ok;

    // Pending settings: written by software at any time.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '{mode: MODE_OFF, duty: '0, hi_cnt: '0, lo_cnt: '0};
        end else if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_MODE: pend.mode   <= pwm_mode_e'(wr_data[1:0]);
                SEL_DUTY: pend.duty   <= wr_data[DUTY_W-1:0];
                SEL_HIGH: pend.hi_cnt <= wr_data[PER_W-1:0];
                SEL_LOW:  pend.lo_cnt <= wr_data[PER_W-1:0];
                default:  pend        <= pend;
            endcase
        end
    end

    // Active settings: taken over only where the running waveform allows.
    always_comb begin
        unique case (act.mode)
            MODE_STD: load_ok = std_wrap;
            MODE_VAR: load_ok = var_wrap;
            default:  load_ok = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            act <= '{mode: MODE_OFF, duty: '0, hi_cnt: '0, lo_cnt: '0};
        else if (load_ok)
            act <= pend;
    end

    pwm_std_engine u_std (
        .clk     (clk),
        .rst     (rst),
        .en      (act.mode == MODE_STD),
        .duty    (act.duty),
        .out     (std_out),
        .at_wrap (std_wrap),
        .idle    (std_idle)
    );

    pwm_fast_engine u_fast (
        .clk  (clk),
        .rst  (rst),
        .en   (act.mode == MODE_FAST),
        .duty (act.duty),
        .out  (fast_out),
        .idle (fast_idle)
    );

    pwm_var_engine u_var (
        .clk     (clk),
        .rst     (rst),
        .en      (act.mode == MODE_VAR),
        .hi_cnt  (act.hi_cnt),
        .lo_cnt  (act.lo_cnt),
        .out     (var_out),
        .at_wrap (var_wrap),
        .idle    (var_idle)
    );

    always_comb begin
        unique case (act.mode)
            MODE_STD:  pwm_out = std_out;
            MODE_FAST: pwm_out = fast_out;
            MODE_VAR:  pwm_out = var_out;
            default:   pwm_out = 1'b0;
        endcase
    end

    // R2: one cycle of off mode leaves every engine cleared.
    a_r2_off_clears: assert property (@(posedge clk) disable iff (rst)
        (act.mode == MODE_OFF) |=> (std_idle && fast_idle && var_idle));

    // R9: the fixed-mode duty holds until the period ends.
    a_r9_std_hold: assert property (@(posedge clk) disable iff (rst)
        (act.mode == MODE_STD && !std_wrap) |=> ($stable(act.duty) && $stable(act.mode)));

    // R9: the variable-mode counts hold until the period ends.
    a_r9_var_hold: assert property (@(posedge clk) disable iff (rst)
        (act.mode == MODE_VAR && !var_wrap) |=>
            ($stable(act.hi_cnt) && $stable(act.lo_cnt) && $stable(act.mode)));

    // R10: in fast mode the pending duty reaches the active copy on the next clock.
    a_r10_fast_follow: assert property (@(posedge clk) disable iff (rst)
        (act.mode == MODE_FAST) |=> (act.duty == $past(pend.duty)));

endmodule

// File: tb/sim_pwm_multimode.sv
module sim_pwm_multimode;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [12:0] wr_data = 13'd0;
    logic        pwm_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_multimode u0 (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    task automatic chk(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic wr(input int sel, input int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = 2'(sel);
        wr_data = 13'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_high(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) c++;
        end
    endtask

    task automatic count_pairs(input int n, output int pairs);
        bit prev;
        pairs = 0;
        prev  = pwm_out;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (prev && pwm_out) pairs++;
            prev = pwm_out;
        end
    endtask

    task automatic wait_rise();
        bit prev;
        prev = pwm_out;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (!prev && pwm_out) return;
            prev = pwm_out;
        end
    endtask

    task automatic measure(output int hi_len, output int lo_len);
        wait_rise();
        hi_len = 1;
        lo_len = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (!pwm_out) break;
            hi_len++;
        end
        lo_len = 1;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (pwm_out) break;
            lo_len++;
        end
    endtask

    // Counts the current high run while issuing one write a few ticks into it.
    task automatic high_run_with_write(input int sel, input int data, output int hi_len);
        wait_rise();
        hi_len = 1;
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (k == 3) begin
                wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 13'(data);
            end else begin
                wr_en = 1'b0;
            end
            if (!pwm_out) break;
            hi_len++;
        end
        wr_en = 1'b0;
    endtask

    function automatic int exp_std_low(input int d);
        return 256 - d;
    endfunction

    initial begin
        int h, l, c, d, hv, lv;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R2: reset state
        count_high(20, c);
        chk("R2 reset output low", c, 0);

        // R1 R3: fixed mode
        wr(1, 100);
        wr(0, 1);
        measure(h, l);
        chk("R3 fixed high", h, 100);
        chk("R3 fixed low", l, exp_std_low(100));

        // R8: period counts ignored in fixed mode
        wr(2, 5);
        wr(3, 7);
        idle_cycles(300);
        measure(h, l);
        chk("R8 fixed high unchanged", h, 100);
        chk("R8 fixed low unchanged", l, 156);

        // R3: zero duty
        wr(1, 0);
        idle_cycles(300);
        count_high(600, c);
        chk("R3 zero duty low", c, 0);

        // R3: random duties
        for (int it = 0; it < 6; it++) begin
            d = 1 + int'($urandom % 254);
            wr(1, d);
            idle_cycles(300);
            measure(h, l);
            chk("R3 random high", h, d);
            chk("R3 random low", l, exp_std_low(d));
        end

        // R9: mid-period duty write in fixed mode
        wr(1, 200);
        idle_cycles(300);
        high_run_with_write(1, 40, h);
        chk("R9 fixed period kept", h, 200);
        measure(h, l);
        chk("R9 fixed next high", h, 40);
        chk("R9 fixed next low", l, 216);

        // R2 R1: off mode
        wr(0, 0);
        idle_cycles(300);
        count_high(300, c);
        chk("R2 off low", c, 0);

        // R7: variable mode entered from off starts high
        wr(2, 2);
        wr(3, 4);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 13'd3;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R7 not yet active", int'(pwm_out), 0);
        @(negedge clk);
        chk("R7 starts high", int'(pwm_out), 1);
        measure(h, l);
        chk("R6 var high", h, 3);
        chk("R6 var low", l, 5);

        // R8: duty ignored in variable mode
        wr(1, 77);
        idle_cycles(20);
        measure(h, l);
        chk("R8 var high unchanged", h, 3);
        chk("R8 var low unchanged", l, 5);

        // R6: minimum counts give a 50 MHz square wave
        wr(2, 0);
        wr(3, 0);
        idle_cycles(20);
        count_high(100, c);
        chk("R6 min counts half high", c, 50);
        measure(h, l);
        chk("R6 min high", h, 1);
        chk("R6 min low", l, 1);

        // R6: random counts
        for (int it = 0; it < 5; it++) begin
            hv = int'($urandom % 300);
            lv = int'($urandom % 300);
            wr(2, hv);
            wr(3, lv);
            idle_cycles(700);
            measure(h, l);
            chk("R6 random high", h, hv + 1);
            chk("R6 random low", l, lv + 1);
        end

        // R9: mid-period count write in variable mode
        wr(2, 50);
        wr(3, 60);
        idle_cycles(700);
        high_run_with_write(2, 10, h);
        chk("R9 var high kept", h, 51);
        measure(h, l);
        chk("R9 var next high", h, 11);
        chk("R9 var next low", l, 61);

        // R6: extremes
        wr(2, 8191);
        wr(3, 0);
        idle_cycles(100);
        measure(h, l);
        chk("R6 max high", h, 8192);
        chk("R6 max high low", l, 1);
        wr(2, 0);
        wr(3, 8191);
        measure(h, l);
        chk("R6 max low high", h, 1);
        chk("R6 max low", l, 8192);

        // R4: fast mode, zero duty
        wr(1, 0);
        wr(0, 2);
        idle_cycles(8300);
        count_high(255, c);
        chk("R4 fast zero low", c, 0);

        // R10: immediate duty change in fast mode
        wr(1, 255);
        @(negedge clk);
        @(negedge clk);
        chk("R10 fast duty applied", int'(pwm_out), 1);
        count_high(255, c);
        chk("R4 fast full high", c, 255);

        // R4 R5: directed and random duties
        for (int it = 0; it < 10; it++) begin
            if (it == 0)      d = 127;
            else if (it == 1) d = 128;
            else              d = int'($urandom % 256);
            wr(1, d);
            idle_cycles(5);
            count_high(255, c);
            chk("R4 fast window count", c, d);
            if (d <= 127) begin
                count_pairs(510, c);
                chk("R5 fast no adjacent highs", c, 0);
            end
        end

        // R2: off from fast acts at once
        wr(0, 0);
        idle_cycles(2);
        count_high(50, c);
        chk("R2 off after fast", c, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule